// File: doc/BRIEF.md
# Leading Digit Anticipator

This combinational block predicts how far an adder result has to be shifted for normalization. It works only from the two operands that feed the adder, so the shift count is ready at about the same time as the sum. The operands arrive already swapped, aligned and conditioned: for an effective subtraction the caller supplies the second operand inverted and normally sets the carry-in to 1. The block handles a run of leading zeros (non-negative difference) and a run of leading ones (negative difference) with the same logic.

Each bit pair is classed as propagate, generate or kill. Above the operand bits sits a sign digit, which is propagate for subtraction and kill for addition. Below them sits a carry digit, which is generate when the carry-in is 1 and kill otherwise. Two indicator sets are formed, one for the zero side and one for the one side. Each indicator looks at one digit and its lower neighbour. Each set is OR-accumulated from the top into a monotonic string, and the two strings are ANDed together. The first set position of that combined string gives the count, which is either exact or one short. The count-may-be-short flag is therefore always raised, so that a later stage can fix both the shift and the exponent from the adder's carries. A separate flag predicts an all-zero result from the operands alone.

Top module: `lda_anticipator`

## Requirements
- R1: Define S as the (WIDTH+1)-bit sum {1'b0,opnd_a} + {eff_sub,opnd_b} + carry_in, and L as the number of consecutive bits of S, starting at its MSB, that equal that MSB. For an effective subtraction with a non-negative difference, lead_count equals L or L-1.
- R2: For an effective subtraction with a negative difference (a run of leading ones), lead_count equals L or L-1.
- R3: For an effective addition (eff_sub=0), including sums that carry into the sign digit, lead_count equals L or L-1.
- R4: The bound of R1 to R3 holds for both carry_in values in both modes.
- R5: With eff_sub=1, result_zero is 1 exactly when every bit of opnd_a differs from the same bit of opnd_b (opnd_a == ~opnd_b). It does not depend on carry_in.
- R6: With eff_sub=0, result_zero is 1 exactly when both operands are all zero. It does not depend on carry_in.
- R7: Whenever result_zero is 1, lead_count equals WIDTH.
- R8: count_may_be_short is always 1.
- R9: lead_count is an unsigned binary value of $clog2(WIDTH+1) bits and never exceeds WIDTH.
- R10: For an effective subtraction with carry_in=1 whose true difference is exactly +1, lead_count equals WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First aligned operand |
| opnd_b | input | WIDTH | Second aligned operand, already inverted for subtraction |
| eff_sub | input | 1 | 1 for an effective subtraction, 0 for an addition |
| carry_in | input | 1 | Carry into the adder's least significant bit |
| lead_count | output | $clog2(WIDTH+1) | Predicted count of leading sign-equal digits of S |
| count_may_be_short | output | 1 | Marks the count as possibly one below the true value |
| result_zero | output | 1 | Predicts a zero result from the operands |

## Verification
The assertions assume that every input bit holds a known 0 or 1. They also assume the indicator strings reach the encoder unchanged, so the combined string is monotonic and at most one first-position marker can fire. No constraint on operand values is needed, because the class of each digit and the count bound are defined for any pair. The stimulus therefore drives every combination of mode and carry-in with fully defined operands. For subtraction it inverts the subtrahend in the bench, so that the intended difference is known exactly when the expected L is computed.

// File: rtl/lda_pkg.sv
package lda_pkg;

    // Structure of the OR-accumulation that turns indicators into a monotonic string.
    typedef enum logic {
        PREFIX_RIPPLE = 1'b0,  // linear chain, smallest area, depth grows with width
        PREFIX_TREE   = 1'b1   // doubling span per level, log depth
    } prefix_kind_e;

endpackage

// File: rtl/lda_classify.sv
// Classes each digit of the extended string as propagate / generate / kill.
// Position 0 is the sign digit, positions 1..WIDTH carry the operands from MSB
// to LSB, and position WIDTH+1 is the carry digit. Only the ranges the
// indicator logic and the zero predictor consume are brought out.
module lda_classify #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             eff_sub,
    input  logic             carry_in,
    output logic [0:WIDTH]   prop_o,
    output logic [1:WIDTH+1] gen_o,
    output logic [1:WIDTH+1] kill_o
);

    // Sign digit: subtraction pairs 0 with 1 (propagate), addition pairs 0 with 0 (kill).
    assign prop_o[0] = eff_sub;

    genvar p;
    generate
        for (p = 1; p <= WIDTH; p++) begin : g_pos
            assign prop_o[p] = opnd_a[WIDTH-p] ^ opnd_b[WIDTH-p];
            assign gen_o[p]  = opnd_a[WIDTH-p] & opnd_b[WIDTH-p];
            assign kill_o[p] = ~(opnd_a[WIDTH-p] | opnd_b[WIDTH-p]);
        end
    endgenerate

    // Carry digit: a generate when a carry enters, a kill otherwise.
    assign gen_o[WIDTH+1]  = carry_in;
    assign kill_o[WIDTH+1] = ~carry_in;

endmodule

// File: rtl/lda_indicator.sv
// One indicator per digit pair (i, i+1). The zero side is fed the kill vector
// and the one side the generate vector; in both cases the indicator fires when
// the digit at i is propagate and its lower neighbour is of the peer class, or
// when neither holds.
module lda_indicator #(
    parameter int WIDTH = 16,
    localparam int NI   = WIDTH + 1
) (
    input  logic [0:NI-1] prop_i,  // propagate at positions 0..WIDTH
    input  logic [0:NI-1] peer_i,  // peer class at positions 1..WIDTH+1
    output logic [0:NI-1] ind_o
);

    genvar i;
    generate
        for (i = 0; i < NI; i++) begin : g_ind
            assign ind_o[i] = ~(prop_i[i] ^ peer_i[i]);
        end
    endgenerate

endmodule

// File: rtl/lda_prefix_or.sv
// Turns an indicator vector into a monotonic string: bit i is the OR of all
// indicators at positions 0..i.
module lda_prefix_or
    import lda_pkg::*;
#(
    parameter int           LEN  = 17,
    parameter prefix_kind_e KIND = PREFIX_TREE
) (
    input  logic [0:LEN-1] ind_i,
    output logic [0:LEN-1] str_o
);

    generate
        if (KIND == PREFIX_RIPPLE) begin : g_ripple
            logic [0:LEN-1] run_d;
            assign run_d[0] = ind_i[0];
            for (genvar i = 1; i < LEN; i++) begin : g_link
                assign run_d[i] = run_d[i-1] | ind_i[i];
            end
            assign str_o = run_d;
        end else begin : g_tree
            localparam int LV = (LEN > 1) ? $clog2(LEN) : 1;
            logic [0:LEN-1] stg_d [0:LV];
            assign stg_d[0] = ind_i;
            for (genvar k = 0; k < LV; k++) begin : g_lvl
                for (genvar i = 0; i < LEN; i++) begin : g_bit
                    if (i >= (1 << k)) begin : g_merge
                        assign stg_d[k+1][i] = stg_d[k][i] | stg_d[k][i-(1<<k)];
                    end else begin : g_pass
                        assign stg_d[k+1][i] = stg_d[k][i];
                    end
                end
            end
            assign str_o = stg_d[LV];
        end
    endgenerate

endmodule

// File: rtl/lda_encode.sv
// ANDs the two monotonic strings, marks the first set position and encodes it
// with AND-OR terms. An empty string yields WIDTH.
module lda_encode #(
    parameter int WIDTH = 16,
    localparam int NI   = WIDTH + 1,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic [0:NI-1]   str_zero_i,
    input  logic [0:NI-1]   str_one_i,
    output logic [0:NI-1]   merged_o,
    output logic [CW-1:0]   lead_count_o
);

    typedef struct packed {
        logic [0:NI-1] merged;
        logic [0:NI-1] first;
        logic [CW-1:0] count;
        logic          none;
    } enc_t;

    enc_t enc_d;

    always_comb begin
        enc_d          = '0;
        enc_d.merged   = str_zero_i & str_one_i;
        enc_d.first[0] = enc_d.merged[0];
        for (int i = 1; i < NI; i++) begin
            enc_d.first[i] = enc_d.merged[i] & ~enc_d.merged[i-1];
        end
        for (int i = 0; i < NI; i++) begin
            if (enc_d.first[i]) begin
                enc_d.count = enc_d.count | CW'(i);
            end
        end
        enc_d.none = ~enc_d.merged[NI-1];
        if (enc_d.none) begin
            enc_d.count = CW'(WIDTH);
        end
    end

    assign merged_o     = enc_d.merged;
    assign lead_count_o = enc_d.count;

    // The strings from the prefix stages are monotonic, so at most one
    // position can be the first set one (R9).
    always_comb begin
        assert_one_pick_R9: assert ($onehot0(enc_d.first))
            else $error("more than one first-position marker");
    end

endmodule

// File: rtl/lda_anticipator.sv
module lda_anticipator
    import lda_pkg::*;
#(
    parameter int           WIDTH       = 16,
    parameter prefix_kind_e PREFIX_KIND = PREFIX_TREE,
    localparam int          CW          = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             eff_sub,
    input  logic             carry_in,
    output logic [CW-1:0]    lead_count,
    output logic             count_may_be_short,
    output logic             result_zero
);

    localparam int NI = WIDTH + 1;

    logic [0:WIDTH]   prop_w;
    logic [1:WIDTH+1] gen_w;
    logic [1:WIDTH+1] kill_w;
    logic [0:NI-1]    ind_zero_w;
    logic [0:NI-1]    ind_one_w;
    logic [0:NI-1]    str_zero_w;
    logic [0:NI-1]    str_one_w;
    logic [0:NI-1]    merged_w;

    lda_classify #(.WIDTH(WIDTH)) u_classify (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .eff_sub  (eff_sub),
        .carry_in (carry_in),
        .prop_o   (prop_w),
        .gen_o    (gen_w),
        .kill_o   (kill_w)
    );

    lda_indicator #(.WIDTH(WIDTH)) u_ind_zero (
        .prop_i (prop_w),
        .peer_i (kill_w),
        .ind_o  (ind_zero_w)
    );

    lda_indicator #(.WIDTH(WIDTH)) u_ind_one (
        .prop_i (prop_w),
        .peer_i (gen_w),
        .ind_o  (ind_one_w)
    );

    lda_prefix_or #(.LEN(NI), .KIND(PREFIX_KIND)) u_pre_zero (
        .ind_i (ind_zero_w),
        .str_o (str_zero_w)
    );

    lda_prefix_or #(.LEN(NI), .KIND(PREFIX_KIND)) u_pre_one (
        .ind_i (ind_one_w),
        .str_o (str_one_w)
    );

    lda_encode #(.WIDTH(WIDTH)) u_encode (
        .str_zero_i   (str_zero_w),
        .str_one_i    (str_one_w),
        .merged_o     (merged_w),
        .lead_count_o (lead_count)
    );

    // Zero prediction from operand classes only (R5, R6).
    assign result_zero        = eff_sub ? (&prop_w[1:WIDTH]) : (&kill_w[1:WIDTH]);
    // The prediction may sit one position early; a later stage corrects it (R8).
    assign count_may_be_short = 1'b1;

    always_comb begin
        assert_count_range_R9: assert (lead_count <= CW'(WIDTH))
            else $error("count above operand width");
        if (result_zero) begin
            assert_zero_full_R7: assert (lead_count == CW'(WIDTH))
                else $error("zero result without full count");
        end
        if (lead_count < CW'(WIDTH)) begin
            assert_count_marks_first_R1: assert (merged_w[lead_count])
                else $error("count does not point at a set string bit");
            if (lead_count != '0) begin
                assert_count_above_clear_R1: assert (!merged_w[lead_count - CW'(1)])
                    else $error("string bit above the counted position is set");
            end
        end
    end

endmodule

// File: tb/lda_anticipator_tb_top.sv
module lda_anticipator_tb_top;

    localparam int W      = 16;
    localparam int CW     = $clog2(W + 1);
    localparam time CLK_P = 20ns;

    logic          clk = 1'b0;
    logic [W-1:0]  opnd_a = '0;
    logic [W-1:0]  opnd_b = '0;
    logic          eff_sub = 1'b0;
    logic          carry_in = 1'b0;
    logic [CW-1:0] lead_count;
    logic          count_may_be_short;
    logic          result_zero;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;
    logic [31:0] seed = 32'h1bad_c0de;

    always #(CLK_P/2) clk = ~clk;

    lda_anticipator #(.WIDTH(W)) dut_i (
        .opnd_a             (opnd_a),
        .opnd_b             (opnd_b),
        .eff_sub            (eff_sub),
        .carry_in           (carry_in),
        .lead_count         (lead_count),
        .count_may_be_short (count_may_be_short),
        .result_zero        (result_zero)
    );

    function automatic logic [31:0] nxt();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [W-1:0] rnd_mag();
        logic [31:0] r = nxt();
        return r[W-1:0] >> r[W+3:W];
    endfunction

    // Run length of bits equal to the MSB of the extended sum.
    function automatic int exp_run(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic sub, input logic ci);
        logic [W:0] s;
        int n;
        bit stop;
        s = {1'b0, a} + {sub, b} + {{W{1'b0}}, ci};
        n = 0;
        stop = 1'b0;
        for (int i = W; i >= 0; i--) begin
            if (!stop && s[i] == s[W]) n++;
            else stop = 1'b1;
        end
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic sub, input logic ci);
        @(posedge clk);
        #2;
        opnd_a = a; opnd_b = b; eff_sub = sub; carry_in = ci;
        @(negedge clk);
    endtask

    task automatic chk_bound(input string req);
        int l, k;
        l = exp_run(opnd_a, opnd_b, eff_sub, carry_in);
        k = int'(lead_count);
        chk((k == l) || (k + 1 == l), req, "count vs run length", k, l);
        chk(k <= W, "R9", "count range", k, W);
    endtask

    task automatic t_idle();
        apply('0, '0, 1'b0, 1'b0);
        chk(int'(lead_count) == W, "R7", "count at quiet inputs", int'(lead_count), W);
        chk(result_zero == 1'b1, "R6", "zero flag at quiet inputs", int'(result_zero), 1);
        chk(count_may_be_short == 1'b1, "R8", "short flag", int'(count_may_be_short), 1);
    endtask

    task automatic t_sub_pos();
        for (int n = 0; n < 200; n++) begin
            logic [W-1:0] x, y, t;
            x = nxt()[W-1:0];
            y = x - rnd_mag();
            if (x < y) begin t = x; x = y; y = t; end
            apply(x, ~y, 1'b1, 1'b1);
            chk_bound("R1");
        end
    endtask

    task automatic t_sub_neg();
        for (int n = 0; n < 200; n++) begin
            logic [W-1:0] x, y, t;
            x = nxt()[W-1:0];
            y = x + rnd_mag() + 1'b1;
            if (x >= y) begin t = x; x = y; y = t; end
            if (x == y) y = x + 1'b1;
            apply(x, ~y, 1'b1, 1'b1);
            chk_bound("R2");
        end
    endtask

    task automatic t_add();
        for (int n = 0; n < 200; n++) begin
            apply(rnd_mag(), (n % 3 == 0) ? nxt()[W-1:0] : rnd_mag(), 1'b0, 1'b0);
            chk_bound("R3");
        end
        for (int j = 0; j < W; j++) begin
            apply(W'(1) << j, '0, 1'b0, 1'b0);
            chk_bound("R3");
            chk(count_may_be_short == 1'b1, "R8", "short flag on walk", int'(count_may_be_short), 1);
        end
        apply('1, '1, 1'b0, 1'b1);
        chk_bound("R3");
    endtask

    task automatic t_carry();
        for (int n = 0; n < 150; n++) begin
            logic [31:0] r = nxt();
            apply(rnd_mag(), r[0] ? ~rnd_mag() : rnd_mag(), r[1], r[2]);
            chk_bound("R4");
        end
    endtask

    task automatic t_zero_sub();
        for (int n = 0; n < 8; n++) begin
            logic [W-1:0] x = nxt()[W-1:0];
            apply(x, ~x, 1'b1, 1'b1);
            chk(result_zero == 1'b1, "R5", "zero flag equal operands", int'(result_zero), 1);
            chk(int'(lead_count) == W, "R7", "count on zero difference", int'(lead_count), W);
            apply(x, ~x, 1'b1, 1'b0);
            chk(result_zero == 1'b1, "R5", "zero flag ignores carry", int'(result_zero), 1);
        end
        for (int j = 0; j < W; j++) begin
            logic [W-1:0] x = nxt()[W-1:0];
            apply(x, ~x ^ (W'(1) << j), 1'b1, 1'b1);
            chk(result_zero == 1'b0, "R5", "zero flag one bit off", int'(result_zero), 0);
        end
    endtask

    task automatic t_zero_add();
        apply('0, '0, 1'b0, 1'b1);
        chk(result_zero == 1'b1, "R6", "zero flag with carry", int'(result_zero), 1);
        chk(int'(lead_count) == W, "R7", "count on zero operands", int'(lead_count), W);
        for (int j = 0; j < W; j++) begin
            apply(W'(1) << j, '0, 1'b0, 1'b0);
            chk(result_zero == 1'b0, "R6", "zero flag a bit set", int'(result_zero), 0);
            apply('0, W'(1) << j, 1'b0, 1'b1);
            chk(result_zero == 1'b0, "R6", "zero flag b bit set", int'(result_zero), 0);
        end
    endtask

    task automatic t_diff_one();
        apply(W'(6), ~W'(5), 1'b1, 1'b1);
        chk(int'(lead_count) == W, "R10", "count for 6-5", int'(lead_count), W);
        for (int n = 0; n < 40; n++) begin
            logic [W-1:0] x = nxt()[W-1:0] | W'(1);
            apply(x, ~(x - 1'b1), 1'b1, 1'b1);
            chk(int'(lead_count) == W, "R10", "count for difference one", int'(lead_count), W);
        end
    endtask

    initial begin
        t_idle();
        t_sub_pos();
        t_sub_neg();
        t_add();
        t_carry();
        t_zero_sub();
        t_zero_add();
        t_diff_one();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule